// File: doc/BRIEF.md
# Multiplexed External Bus Byte-Lane Controller

This block sits between a 16-bit processor core and a multiplexed address/data external bus. The bus has two byte lanes. In the address phase both lanes carry address bits, and an address latch strobe lets an external transparent latch capture them. In the data phase the lanes turn around to carry data. The block produces the read strobe, a pair of per-byte write strobes and an active-low byte-high-enable. Read data gathered from the lanes goes back to the core.

A width-select input picks between a 16-bit bus and an 8-bit bus. On the 16-bit bus the even byte travels on the low lane and the odd byte on the high lane. On the 8-bit bus every data byte travels on the low lane, the high lane keeps presenting address, and a word access is split into two byte transfers. A quiet-control input, when set, keeps the read and write strobes inactive on accesses the core flags as internal-memory accesses. External data is never returned for such reads.

The core raises `req` with address, direction, byte enables and write data, and holds them until `rdy` pulses. The width select and quiet control are captured when the request is taken.

Top module: `mux_bus_lane_ctrl`

## Requirements
- R1: Every bus transfer is one address-phase clock followed by one data-phase clock. In the address phase `ale` is 1, both lanes are enabled and carry address bits 7..0 (low lane) and 15..8 (high lane), and `rd_n`, `wr_lo_n` and `wr_hi_n` are all 1. In the data phase `ale` is 0. `rdy` is 1 for exactly one clock, the clock after the last data phase, and a 16-bit-mode access uses a single transfer.
- R2: In 16-bit mode (`sel_narrow`=0), the byte enables are `req_be[0]` for the even byte and `req_be[1]` for the odd byte, and `req_be`=00 is treated as 11. Address bit 0 on the low lane is 1 only when `req_be`=10. `bhe_n` is 0 during both phases exactly when the odd byte is enabled.
- R3: In a 16-bit-mode write data phase, both lanes are enabled, the low lane carries `req_wdata[7:0]` and the high lane carries `req_wdata[15:8]`.
- R4: In a 16-bit-mode write data phase, `wr_lo_n` is 0 exactly when the even byte is enabled and `wr_hi_n` is 0 exactly when the odd byte is enabled.
- R5: `rd_n` is 0 only in the data phase of a read. In that phase the low lane is released (output enable 0), and in 16-bit mode so is the high lane. A 16-bit read returns `{high lane, low lane}` as sampled at the end of the data phase, with a byte that is not enabled returned as zero.
- R6: In 8-bit mode (`sel_narrow`=1), the high lane drives address bits 15..8 in both phases. A word access becomes two transfers, the first with address bit 0 = 0 and the second with address bit 0 = 1. A single-byte access is one transfer with address bit 0 = 1 for the odd byte and 0 for the even byte. `bhe_n` is 0 only during an odd-byte transfer.
- R7: In an 8-bit-mode write data phase, the low lane carries `req_wdata[7:0]` for the even transfer and `req_wdata[15:8]` for the odd transfer, `wr_lo_n` is 0, and `wr_hi_n` stays 1 throughout.
- R8: An 8-bit-mode read places the byte sampled in the even transfer in `rdata[7:0]` and the byte sampled in the odd transfer in `rdata[15:8]`. A byte that was not transferred is zero.
- R9: When the captured quiet control is 1 and the access is flagged internal, `rd_n`, `wr_lo_n` and `wr_hi_n` stay 1 for the whole access, while the address and data phases, `ale` and the lanes behave as usual.
- R10: On an internal read, and on any write, `rdata` is zero when `rdy` pulses, whatever the lanes carry.
- R11: While no access is in progress, `ale` is 0, both lane output enables are 0, all strobes and `bhe_n` are 1, and `addr_up` is 0. During an access, `addr_up` carries address bits above bit 15.
- R12: A request is taken only when no access is in progress and `rdy` is 0, so a `req` still held during the `rdy` clock starts nothing in the next clock. `sel_narrow` and `sel_quiet` are sampled when the request is taken, and later changes do not affect that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_narrow | input | 1 | Bus width select: 0 = 16-bit bus, 1 = 8-bit bus |
| sel_quiet | input | 1 | 1 = keep strobes inactive on internal accesses |
| req | input | 1 | Core access request, held until `rdy` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_internal | input | 1 | Access targets internal memory |
| req_be | input | 2 | Byte enables: bit 0 even byte, bit 1 odd byte |
| req_addr | input | ADDR_W-1 | Word address (byte address bits ADDR_W-1..1) |
| req_wdata | input | 2*LANE_W | Write data, even byte in the low half |
| rdy | output | 1 | One-clock access-done pulse |
| rdata | output | 2*LANE_W | Read data, valid while `rdy` is 1 |
| addr_up | output | ADDR_W-2*LANE_W | Address bits above the two lanes |
| lo_out | output | LANE_W | Low lane output value |
| lo_oe | output | 1 | Low lane output enable |
| lo_in | input | LANE_W | Low lane input value |
| hi_out | output | LANE_W | High lane output value |
| hi_oe | output | 1 | High lane output enable |
| hi_in | input | LANE_W | High lane input value |
| ale | output | 1 | Address latch strobe, 1 in the address phase |
| rd_n | output | 1 | Active-low read strobe |
| wr_lo_n | output | 1 | Active-low write strobe, low lane |
| wr_hi_n | output | 1 | Active-low write strobe, high lane |
| bhe_n | output | 1 | Active-low byte-high-enable |

## Verification
The bench sweeps every combination of bus width, direction, byte-enable pattern, internal flag and quiet control. It checks each phase of every transfer against values derived from the byte-enable arithmetic. The corner cases it aims at are these:
- the empty byte-enable pattern, where a design that failed to widen it would run a strobeless cycle;
- the odd-only access, where a wrong address bit 0 or a misplaced byte-high-enable addresses the wrong byte;
- the 8-bit word access, where a design that skipped the second transfer, or gathered bytes into the wrong halves, returns a half-empty or byte-swapped word;
- the high lane on the 8-bit bus, which must keep address and never see a write strobe.

A second pass flips the width and quiet inputs right after acceptance and holds the request through the done pulse. A design that decoded those inputs live, or that re-accepted on the done clock, would run the wrong access or a spurious one.

// File: rtl/mbl_pkg.sv
package mbl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // Attributes of an accepted access, frozen for its whole duration.
  typedef struct packed {
    logic       we;
    logic [1:0] be;        // already widened: never 2'b00
    logic       internal;
    logic       narrow;    // 1 = 8-bit bus
    logic       quiet;     // 1 = mask strobes on internal accesses
  } acc_t;

  // An empty enable pattern is taken as a full word.
  function automatic logic [1:0] be_fill(input logic [1:0] be);
    return (be == 2'b00) ? 2'b11 : be;
  endfunction

  // 8-bit bus, odd byte only: the single transfer starts on the odd byte.
  function automatic logic start_odd(input logic narrow, input logic [1:0] be);
    return narrow && (be == 2'b10);
  endfunction

  // 8-bit bus word access still owes its odd transfer.
  function automatic logic more_xfer(input logic narrow, input logic [1:0] be,
                                     input logic odd);
    return narrow && (be == 2'b11) && !odd;
  endfunction

  // Address bit 0 presented on the bus.
  function automatic logic addr_lsb(input logic narrow, input logic [1:0] be,
                                    input logic odd);
    return narrow ? odd : (be == 2'b10);
  endfunction

  // Byte-high-enable active (before inversion).
  function automatic logic bhe_on(input logic narrow, input logic [1:0] be,
                                  input logic odd);
    return narrow ? odd : be[1];
  endfunction

  function automatic logic wlo_on(input logic narrow, input logic [1:0] be);
    return narrow || be[0];
  endfunction

  function automatic logic whi_on(input logic narrow, input logic [1:0] be);
    return !narrow && be[1];
  endfunction

endpackage

// File: rtl/mbl_seq.sv
module mbl_seq
  import mbl_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_internal,
  input  logic [1:0]        req_be,
  input  logic [ADDR_W-1:1] req_addr,
  input  logic              sel_narrow,
  input  logic              sel_quiet,
  output phase_t            phase,
  output acc_t              acc,
  output logic              odd_xfer,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              rdy,
  output logic              take
);

  logic [ADDR_W-1:1] addr_q;
  logic              rdy_q;
  logic              ph_addr;
  logic              ph_data;
  logic              owe_more;
  logic [1:0]        be_in;

  assign ph_addr  = (phase == PH_ADDR);
  assign ph_data  = (phase == PH_DATA);
  assign be_in    = be_fill(req_be);
  assign take     = (phase == PH_IDLE) && req && !rdy_q;
  assign owe_more = more_xfer(acc.narrow, acc.be, odd_xfer);
  assign bus_addr = {addr_q, addr_lsb(acc.narrow, acc.be, odd_xfer)};
  assign rdy      = rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      acc      <= '0;
      addr_q   <= '0;
      odd_xfer <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (take) begin
            phase        <= PH_ADDR;
            addr_q       <= req_addr;
            acc.we       <= req_we;
            acc.be       <= be_in;
            acc.internal <= req_internal;
            acc.narrow   <= sel_narrow;
            acc.quiet    <= sel_quiet;
            odd_xfer     <= start_odd(sel_narrow, be_in);
          end
        end
        PH_ADDR: phase <= PH_DATA;
        PH_DATA: begin
          if (owe_more) begin
            phase    <= PH_ADDR;
            odd_xfer <= 1'b1;
          end else begin
            phase <= PH_IDLE;
            rdy_q <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ph_addr |=> ph_data); // R1
  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q); // R1
  AST_RDY_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> $past(ph_data)); // R1
  AST_NO_RETAKE_ON_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> (phase == PH_IDLE)); // R12
  AST_SECOND_IS_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_data && owe_more) |=> (ph_addr && odd_xfer)); // R6

endmodule

// File: rtl/mbl_lane_drv.sv
module mbl_lane_drv
  import mbl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  phase_t                       phase,
  input  acc_t                         acc,
  input  logic                         odd_xfer,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [2*LANE_W-1:0]          wdata,
  output logic [1:0][LANE_W-1:0]       lane_out,
  output logic [1:0]                   lane_oe
);

  localparam int N_LANES = 2;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a_byte;
    logic [LANE_W-1:0] d_byte;
    logic              keep_addr;
    logic [LANE_W-1:0] l_out;
    logic              l_oe;

    assign a_byte = bus_addr[g*LANE_W +: LANE_W];

    if (g == 0) begin : g_even
      // 8-bit bus: the odd byte also travels on this lane.
      assign d_byte    = (acc.narrow && odd_xfer) ? wdata[LANE_W +: LANE_W]
                                                  : wdata[0 +: LANE_W];
      assign keep_addr = 1'b0;
    end else begin : g_odd
      assign d_byte    = wdata[LANE_W +: LANE_W];
      assign keep_addr = acc.narrow;
    end

    always_comb begin
      l_out = '0;
      l_oe  = 1'b0;
      unique case (phase)
        PH_ADDR: begin
          l_out = a_byte;
          l_oe  = 1'b1;
        end
        PH_DATA: begin
          if (keep_addr) begin
            l_out = a_byte;
            l_oe  = 1'b1;
          end else if (acc.we) begin
            l_out = d_byte;
            l_oe  = 1'b1;
          end
        end
        default: begin
          l_out = '0;
          l_oe  = 1'b0;
        end
      endcase
    end

    assign lane_out[g] = l_out;
    assign lane_oe[g]  = l_oe;
  end

  AST_READ_RELEASES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !acc.we) |-> !lane_oe[0]); // R5
  AST_IDLE_LANES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (lane_oe == 2'b00)); // R11
  AST_NARROW_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && acc.narrow) |-> (lane_oe[1] && $stable(lane_out[1]))); // R6

endmodule

// File: rtl/mbl_strobe.sv
module mbl_strobe
  import mbl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  input  acc_t   acc,
  input  logic   odd_xfer,
  output logic   ale,
  output logic   rd_n,
  output logic   wr_lo_n,
  output logic   wr_hi_n,
  output logic   bhe_n
);

  logic in_cycle;
  logic in_data;
  logic masked;
  logic rd_go;
  logic wr_go;

  assign in_cycle = (phase != PH_IDLE);
  assign in_data  = (phase == PH_DATA);
  assign masked   = acc.internal && acc.quiet;
  assign rd_go    = in_data && !acc.we && !masked;
  assign wr_go    = in_data &&  acc.we && !masked;

  assign ale     = (phase == PH_ADDR);
  assign rd_n    = !rd_go;
  assign wr_lo_n = !(wr_go && wlo_on(acc.narrow, acc.be));
  assign wr_hi_n = !(wr_go && whi_on(acc.narrow, acc.be));
  assign bhe_n   = !(in_cycle && bhe_on(acc.narrow, acc.be, odd_xfer));

  AST_READ_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> $past(ale)); // R5
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wr_lo_n && wr_hi_n)); // R5
  AST_NARROW_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc.narrow |-> wr_hi_n); // R7
  AST_MASKED_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cycle && masked) |-> (rd_n && wr_lo_n && wr_hi_n)); // R9
  AST_BHE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> $stable(bhe_n)); // R2

endmodule

// File: rtl/mbl_rd_gather.sv
module mbl_rd_gather
  import mbl_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  phase_t                 phase,
  input  acc_t                   acc,
  input  logic                   odd_xfer,
  input  logic [1:0][LANE_W-1:0] lane_in,
  output logic [2*LANE_W-1:0]    rdata
);

  logic sample;

  // External data is only taken on reads of external memory.
  assign sample = (phase == PH_DATA) && !acc.we && !acc.internal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (take) begin
      rdata <= '0;
    end else if (sample) begin
      if (acc.narrow) begin
        if (odd_xfer) rdata[LANE_W +: LANE_W] <= lane_in[0];
        else          rdata[0 +: LANE_W]      <= lane_in[0];
      end else begin
        rdata[0 +: LANE_W]      <= acc.be[0] ? lane_in[0] : '0;
        rdata[LANE_W +: LANE_W] <= acc.be[1] ? lane_in[1] : '0;
      end
    end
  end

  AST_INTERNAL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && acc.internal) |=> (rdata == '0)); // R10
  AST_WRITES_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && acc.we) |=> (rdata == '0)); // R10

endmodule

// File: rtl/mux_bus_lane_ctrl.sv
module mux_bus_lane_ctrl
  import mbl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sel_narrow,
  input  logic                           sel_quiet,
  input  logic                           req,
  input  logic                           req_we,
  input  logic                           req_internal,
  input  logic [1:0]                     req_be,
  input  logic [ADDR_W-1:1]              req_addr,
  input  logic [2*LANE_W-1:0]            req_wdata,
  output logic                           rdy,
  output logic [2*LANE_W-1:0]            rdata,
  output logic [ADDR_W-2*LANE_W-1:0]     addr_up,
  output logic [LANE_W-1:0]              lo_out,
  output logic                           lo_oe,
  input  logic [LANE_W-1:0]              lo_in,
  output logic [LANE_W-1:0]              hi_out,
  output logic                           hi_oe,
  input  logic [LANE_W-1:0]              hi_in,
  output logic                           ale,
  output logic                           rd_n,
  output logic                           wr_lo_n,
  output logic                           wr_hi_n,
  output logic                           bhe_n
);

  localparam int LANE_SPAN = 2 * LANE_W;
  localparam int UP_W      = ADDR_W - LANE_SPAN;

  phase_t                 phase;
  acc_t                   acc;
  logic                   odd_xfer;
  logic                   take;
  logic [ADDR_W-1:0]      bus_addr;
  logic [1:0][LANE_W-1:0] lane_out;
  logic [1:0]             lane_oe;
  logic [1:0][LANE_W-1:0] lane_in;
  logic                   busy;

  mbl_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .req_we       (req_we),
    .req_internal (req_internal),
    .req_be       (req_be),
    .req_addr     (req_addr),
    .sel_narrow   (sel_narrow),
    .sel_quiet    (sel_quiet),
    .phase        (phase),
    .acc          (acc),
    .odd_xfer     (odd_xfer),
    .bus_addr     (bus_addr),
    .rdy          (rdy),
    .take         (take)
  );

  mbl_lane_drv #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .acc      (acc),
    .odd_xfer (odd_xfer),
    .bus_addr (bus_addr),
    .wdata    (req_wdata),
    .lane_out (lane_out),
    .lane_oe  (lane_oe)
  );

  mbl_strobe u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .acc      (acc),
    .odd_xfer (odd_xfer),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_lo_n  (wr_lo_n),
    .wr_hi_n  (wr_hi_n),
    .bhe_n    (bhe_n)
  );

  assign lane_in[0] = lo_in;
  assign lane_in[1] = hi_in;

  mbl_rd_gather #(.LANE_W(LANE_W)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .phase    (phase),
    .acc      (acc),
    .odd_xfer (odd_xfer),
    .lane_in  (lane_in),
    .rdata    (rdata)
  );

  assign busy    = (phase != PH_IDLE);
  assign lo_out  = lane_out[0];
  assign hi_out  = lane_out[1];
  assign lo_oe   = lane_oe[0];
  assign hi_oe   = lane_oe[1];
  assign addr_up = busy ? bus_addr[ADDR_W-1:LANE_SPAN] : {UP_W{1'b0}};

  AST_UPPER_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (addr_up == '0 && !ale)); // R11
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> $stable(addr_up)); // R11

endmodule

// File: tb/mux_bus_lane_ctrl_test.sv
`timescale 1ns/1ps
module mux_bus_lane_ctrl_test;

  localparam int AW = 20;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_narrow, sel_quiet;
  logic          req, req_we, req_internal;
  logic [1:0]    req_be;
  logic [AW-1:1] req_addr;
  logic [15:0]   req_wdata;
  logic          rdy;
  logic [15:0]   rdata;
  logic [AW-17:0] addr_up;
  logic [7:0]    lo_out, hi_out, lo_in, hi_in;
  logic          lo_oe, hi_oe, ale, rd_n, wr_lo_n, wr_hi_n, bhe_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  mux_bus_lane_ctrl #(.ADDR_W(AW), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .sel_narrow(sel_narrow), .sel_quiet(sel_quiet),
    .req(req), .req_we(req_we), .req_internal(req_internal), .req_be(req_be),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdy(rdy), .rdata(rdata),
    .addr_up(addr_up), .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in),
    .hi_out(hi_out), .hi_oe(hi_oe), .hi_in(hi_in), .ale(ale), .rd_n(rd_n),
    .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .bhe_n(bhe_n)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // R11: quiet bus between accesses
  task automatic chk_idle(input string tag);
    chk(tag, "idle controls {ale,lo_oe,hi_oe,rd_n,wr_lo_n,wr_hi_n,bhe_n,rdy}",
        {ale, lo_oe, hi_oe, rd_n, wr_lo_n, wr_hi_n, bhe_n, rdy}, 8'b0001_1110);
    chk(tag, "idle upper address", addr_up, 0);
  endtask

  task automatic run_access(input logic narrow, input logic we, input logic [1:0] be,
                            input logic intl, input logic quiet,
                            input logic [AW-1:1] wa, input logic [15:0] wd,
                            input logic flip, input logic hold);
    logic [1:0]    bf;
    int            nx;
    logic          supp;
    logic [15:0]   exp_rd;
    logic          odd, a0, bhe_x;
    logic [AW-1:0] fa;
    string         t_bhe, t_rd, t_wlo, t_whi, t_lo, t_hi, t_rdata;
    bf     = (be == 2'b00) ? 2'b11 : be;
    nx     = (narrow && bf == 2'b11) ? 2 : 1;
    supp   = intl && quiet;
    exp_rd = 16'h0000;

    @(negedge clk);
    sel_narrow = narrow; sel_quiet = quiet;
    req = 1'b1; req_we = we; req_be = be; req_internal = intl;
    req_addr = wa; req_wdata = wd;

    for (int t = 0; t < nx; t++) begin
      if (narrow) odd = (nx == 2) ? (t == 1) : (bf == 2'b10);
      else        odd = 1'b0;
      a0    = narrow ? odd : (bf == 2'b10);
      fa    = {wa, a0};
      bhe_x = narrow ? !odd : !bf[1];
      if (narrow) t_bhe = "R6"; else t_bhe = "R2";
      if (supp) begin t_rd = "R9"; t_wlo = "R9"; t_whi = "R9"; end
      else begin
        t_rd = "R5";
        if (narrow) begin t_wlo = "R7"; t_whi = "R7"; end
        else        begin t_wlo = "R4"; t_whi = "R4"; end
      end
      if (!we) t_lo = "R5"; else if (narrow) t_lo = "R7"; else t_lo = "R3";
      if (narrow) t_hi = "R6"; else if (we) t_hi = "R3"; else t_hi = "R5";

      // address phase
      @(negedge clk);
      if (flip && t == 0) begin
        sel_narrow = !narrow;   // R12: must not affect the running access
        sel_quiet  = !quiet;
      end
      chk("R1", "ale in address phase", ale, 1);
      chk("R1", "lane enables in address phase", {lo_oe, hi_oe}, 2'b11);
      chk(narrow ? "R6" : "R2", "low lane address with A0", lo_out, fa[7:0]);
      chk("R1", "high lane address", hi_out, fa[15:8]);
      chk(t_bhe, "bhe_n in address phase", bhe_n, bhe_x);
      chk("R11", "upper address in address phase", addr_up, fa[AW-1:16]);
      chk("R1", "strobes high in address phase", {rd_n, wr_lo_n, wr_hi_n}, 3'b111);

      // data phase
      @(negedge clk);
      lo_in = wa[8:1] ^ 8'hA5 ^ (t == 1 ? 8'h3C : 8'h00);
      hi_in = ~wa[9:2];
      chk("R1", "ale in data phase", ale, 0);
      chk("R1", "rdy low in data phase", rdy, 0);
      chk(t_rd, "rd_n in data phase", rd_n, !(!we && !supp));
      chk(t_wlo, "wr_lo_n in data phase", wr_lo_n, !(we && !supp && (narrow || bf[0])));
      chk(t_whi, "wr_hi_n in data phase", wr_hi_n, !(we && !supp && !narrow && bf[1]));
      chk(t_lo, "low lane enable in data phase", lo_oe, we);
      if (we)
        chk(t_lo, "low lane write byte", lo_out, (narrow && odd) ? wd[15:8] : wd[7:0]);
      chk(t_hi, "high lane enable in data phase", hi_oe, narrow ? 1'b1 : we);
      if (narrow)  chk("R6", "high lane keeps address", hi_out, fa[15:8]);
      else if (we) chk("R3", "high lane write byte", hi_out, wd[15:8]);
      chk(t_bhe, "bhe_n in data phase", bhe_n, bhe_x);
      chk("R11", "upper address in data phase", addr_up, fa[AW-1:16]);

      if (!we && !intl) begin
        if (narrow) begin
          if (odd) exp_rd[15:8] = lo_in;
          else     exp_rd[7:0]  = lo_in;
        end else begin
          exp_rd = {bf[1] ? hi_in : 8'h00, bf[0] ? lo_in : 8'h00};
        end
      end
    end

    // done clock
    @(negedge clk);
    if (we || intl) t_rdata = "R10"; else if (narrow) t_rdata = "R8"; else t_rdata = "R5";
    chk("R1", "rdy pulse after last data phase", rdy, 1);
    chk("R1", "ale low in rdy clock", ale, 0);
    chk(t_rdata, "returned read data", rdata, exp_rd);
    if (!hold) req = 1'b0;

    @(negedge clk);
    if (hold) chk("R12", "no restart from req held over rdy", {ale, rdy}, 2'b00);
    req = 1'b0;
    chk_idle("R11");
  endtask

  initial begin
    rst_n = 1'b0; sel_narrow = 1'b0; sel_quiet = 1'b0; req = 1'b0; req_we = 1'b0;
    req_internal = 1'b0; req_be = 2'b00; req_addr = '0; req_wdata = 16'h0;
    lo_in = 8'h00; hi_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R11");
    chk("R10", "read data after reset", rdata, 0);

    for (int pass = 0; pass < 2; pass++) begin
      for (int m = 0; m < 64; m++) begin
        logic [AW-1:1] wa;
        logic [15:0]   wd;
        wa = (AW-1)'(m * 32'h2_4B3D + pass * 32'h5_1111 + 32'h1E1);
        wd = 16'(m * 16'h01F3) ^ 16'hC0DE;
        run_access(m[5], m[4], 2'(m[3:2]), m[1], m[0], wa, wd,
                   pass == 1, (m % 5) == 0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule